// File: doc/BRIEF.md
# Register Pointer With Time Snapshot

This block is the byte-level register space behind a serial-bus slave. The bus front end hands it strobes: a START, a STOP, a written byte with its data, and a read request. The space has 64 bytes. The low eight bytes are the timekeeping registers and a control byte, and the remaining bytes are general-purpose RAM. A single register pointer addresses the space. The first byte written after a START loads the pointer. Every later data byte and every read uses the pointer and then moves it forward by one.

Time is read from a user copy of the live counters and never from the counters themselves. The copy is refreshed on START, on STOP and when the pointer wraps to zero, so a multibyte read returns one consistent instant while the counters keep running. Writes to time bytes also go into the user copy. They are marked pending and are committed to the live counters in one cycle at STOP. The commit also clears the sub-second prescaler, so the first new second takes a full period.

Top module: `rtc_snap_regs`

## Requirements
- R1: After reset the time bytes 0..6 read 00,00,00,01,01,01,00 and the control byte 7 reads 00. `rdata_o` is 00 and `rvalid_o` is low.
- R2: The first `wr_i` after a `start_i` loads the pointer from `wdata_i[5:0]`. Each later `wr_i` stores its byte at the pointer, and each `rd_i` reads the byte at the pointer. Both then increment the pointer. Read data appears on `rdata_o` with `rvalid_o` high one cycle after `rd_i`.
- R3: The pointer increments from 3Fh to 00h.
- R4: Addresses 08h..3Fh are RAM. They are read and written directly, with no copy and no commit.
- R5: On `start_i`, every time byte without a pending write is copied from the live counters into the user copy.
- R6: On `stop_i`, the user copy takes the live counters, including any values committed in that cycle.
- R7: When a read or write increments the pointer to 00h, the non-pending time bytes are copied from the live counters.
- R8: Reads of 00h..06h return the user copy. The copy does not change between snapshot events, even while the live counters advance.
- R9: A write to 00h..06h changes only the user copy and marks that byte pending. A pending byte survives START and wrap snapshots. At STOP all pending bytes load the live counters and the prescaler is cleared.
- R10: Every PRESC_DIV `osc_tick_i` pulses advance the seconds. The byte layout is: byte 0 seconds (bits 6:0, BCD 00-59); 1 minutes 00-59; 2 hours 00-23; 3 weekday 1-7; 4 date 01-28/29/30/31; 5 month 01-12; 6 year 00-99, all in BCD. Carries ripple upward. The weekday and date advance at midnight. Months 04, 06, 09 and 11 have 30 days. February has 29 days when the year is a multiple of 4 and 28 otherwise.
- R11: While bit 7 of live byte 0 is 1, the prescaler and all counters hold.
- R12: When a snapshot event falls in the same cycle as a seconds advance, the copy holds the advanced value.
- R13: Byte 07h is a control register, read and written directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Bus START seen (one-cycle strobe) |
| stop_i | input | 1 | Bus STOP seen (one-cycle strobe) |
| wr_i | input | 1 | Written byte available |
| wdata_i | input | 8 | Written byte |
| rd_i | input | 1 | Read byte requested |
| osc_tick_i | input | 1 | Oscillator tick into the prescaler |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | `rdata_o` valid |

## Verification
The bench goes after the three refresh points one at a time. A design that skipped a refresh would return a stale second after a repeated START, after a STOP, or after a read that runs through 3Fh into 00h. It also checks that the copy stays frozen while the live counter runs ahead, so a design reading live counters shows the torn value. The pending-write rules are checked too. A repeated START must not overwrite an uncommitted byte, and the prescaler must restart at commit, or the next second arrives early. The calendar carries are checked at month ends, in a leap and a non-leap February, and at the year wrap. A START in the same cycle as a seconds tick must capture the post-tick second, not the older one.

// File: rtl/rtc_snap_pkg.sv
package rtc_snap_pkg;

  localparam int TIME_REGS = 7;
  localparam int CTRL_ADDR = TIME_REGS;
  localparam int RAM_BASE  = TIME_REGS + 1;

  typedef logic [TIME_REGS-1:0][7:0] time_vec_t;

  // byte lanes of the time vector
  localparam int I_SEC  = 0;
  localparam int I_MIN  = 1;
  localparam int I_HOUR = 2;
  localparam int I_DOW  = 3;
  localparam int I_DATE = 4;
  localparam int I_MON  = 5;
  localparam int I_YEAR = 6;

  localparam time_vec_t TIME_RST = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // {wrapped, next} for a BCD counter running lo..hi
  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] hi,
                                          input logic [7:0] lo);
    if (v >= hi) return {1'b1, lo};
    if (v[3:0] >= 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    return {1'b0, v + 8'd1};
  endfunction

  function automatic logic leap_bcd(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_bcd(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_snap_ptr.sv
module rtc_snap_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              ptr_load_o,
  output logic              wrap_o
);

  logic [ADDR_W-1:0] ptr_q;
  logic              pend_q;
  logic              adv;

  assign ptr_load_o = wr_i && pend_q;
  assign adv        = rd_i || (wr_i && !pend_q);
  assign wrap_o     = adv && !start_i && (ptr_q == {ADDR_W{1'b1}});
  assign ptr_o      = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
    end else if (start_i) begin
      pend_q <= 1'b1;
    end else if (ptr_load_o) begin
      ptr_q  <= wdata_i[ADDR_W-1:0];
      pend_q <= 1'b0;
    end else if (adv) begin
      ptr_q  <= ptr_q + 1'b1;
    end
  end

  a_r3_ptr_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && !start_i && !ptr_load_o && ptr_q == {ADDR_W{1'b1}}) |=> (ptr_q == '0));

  a_r2_ptr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_load_o && !start_i) |=> (ptr_q == $past(wdata_i[ADDR_W-1:0])));

endmodule

// File: rtl/rtc_snap_core.sv
module rtc_snap_core
  import rtc_snap_pkg::*;
#(
  parameter int PRESC_DIV = 32768
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 osc_tick_i,
  input  logic [TIME_REGS-1:0] load_en_i,
  input  time_vec_t            load_val_i,
  output time_vec_t            live_o,
  output time_vec_t            live_nxt_o
);

  localparam int CNT_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESC_DIV - 1);

  time_vec_t        live_q, nxt;
  logic [CNT_W-1:0] pre_q, pre_nxt;
  logic             halt, load_any, sec_pulse;
  logic [8:0]       s_sec, s_min, s_hr, s_dow, s_date, s_mon, s_yr;

  assign halt      = live_q[I_SEC][7];
  assign load_any  = |load_en_i;
  assign sec_pulse = osc_tick_i && !halt && !load_any && (pre_q == CNT_LAST);

  always_comb begin
    if (load_any)                pre_nxt = '0;
    else if (osc_tick_i && !halt) pre_nxt = (pre_q == CNT_LAST) ? '0 : pre_q + 1'b1;
    else                         pre_nxt = pre_q;
  end

  always_comb begin
    s_sec  = bcd_step({1'b0, live_q[I_SEC][6:0]}, 8'h59, 8'h00);
    s_min  = bcd_step(live_q[I_MIN], 8'h59, 8'h00);
    s_hr   = bcd_step(live_q[I_HOUR], 8'h23, 8'h00);
    s_dow  = bcd_step(live_q[I_DOW], 8'h07, 8'h01);
    s_date = bcd_step(live_q[I_DATE], month_end(live_q[I_MON], live_q[I_YEAR]), 8'h01);
    s_mon  = bcd_step(live_q[I_MON], 8'h12, 8'h01);
    s_yr   = bcd_step(live_q[I_YEAR], 8'h99, 8'h00);

    nxt = live_q;
    if (load_any) begin
      for (int i = 0; i < TIME_REGS; i++)
        if (load_en_i[i]) nxt[i] = load_val_i[i];
    end else if (sec_pulse) begin
      nxt[I_SEC] = s_sec[7:0];
      if (s_sec[8]) begin
        nxt[I_MIN] = s_min[7:0];
        if (s_min[8]) begin
          nxt[I_HOUR] = s_hr[7:0];
          if (s_hr[8]) begin
            nxt[I_DOW]  = s_dow[7:0];
            nxt[I_DATE] = s_date[7:0];
            if (s_date[8]) begin
              nxt[I_MON] = s_mon[7:0];
              if (s_mon[8]) nxt[I_YEAR] = s_yr[7:0];
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= TIME_RST;
      pre_q  <= '0;
    end else begin
      live_q <= nxt;
      pre_q  <= pre_nxt;
    end
  end

  assign live_o     = live_q;
  assign live_nxt_o = nxt;

  a_r11_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !load_any) |=> ($stable(live_q) && $stable(pre_q)));

  a_r9_presc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_any |=> (pre_q == '0));

endmodule

// File: rtl/rtc_snap_ram.sv
module rtc_snap_ram #(
  parameter int ADDR_W = 6,
  parameter int BASE   = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam int WORDS = (1 << ADDR_W) - BASE;

  logic [7:0]        mem [WORDS];
  logic [ADDR_W-1:0] off;

  assign off     = (addr_i >= ADDR_W'(BASE)) ? addr_i - ADDR_W'(BASE) : '0;
  assign rdata_o = mem[off];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[off] <= wdata_i;
  end

endmodule

// File: rtl/rtc_snap_regs.sv
module rtc_snap_regs
  import rtc_snap_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int PRESC_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       rd_i,
  input  logic       osc_tick_i,
  output logic [7:0] rdata_o,
  output logic       rvalid_o
);

  logic [ADDR_W-1:0]    ptr;
  logic                 ptr_load, wrap, wr_data, snap;
  logic [TIME_REGS-1:0] dirty_q, load_en;
  time_vec_t            usr_q, live, live_nxt;
  logic [7:0]           ctrl_q, ram_rd, rd_byte;
  logic                 ram_we;

  rtc_snap_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i, .rst_ni, .start_i, .wr_i, .rd_i, .wdata_i,
    .ptr_o(ptr), .ptr_load_o(ptr_load), .wrap_o(wrap)
  );

  assign wr_data = wr_i && !ptr_load && !start_i;
  assign snap    = start_i || stop_i || wrap;
  assign load_en = stop_i ? dirty_q : '0;
  assign ram_we  = wr_data && (ptr >= ADDR_W'(RAM_BASE));

  rtc_snap_core #(.PRESC_DIV(PRESC_DIV)) u_core (
    .clk_i, .rst_ni, .osc_tick_i,
    .load_en_i(load_en), .load_val_i(usr_q),
    .live_o(live), .live_nxt_o(live_nxt)
  );

  rtc_snap_ram #(.ADDR_W(ADDR_W), .BASE(RAM_BASE)) u_ram (
    .clk_i, .we_i(ram_we), .addr_i(ptr), .wdata_i, .rdata_o(ram_rd)
  );

  // user copy: pending writes win, STOP settles everything, other events refresh clean bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      usr_q   <= TIME_RST;
      dirty_q <= '0;
      ctrl_q  <= '0;
    end else begin
      for (int i = 0; i < TIME_REGS; i++) begin
        if (wr_data && ptr == ADDR_W'(i)) begin
          usr_q[i]   <= wdata_i;
          dirty_q[i] <= 1'b1;
        end else if (stop_i) begin
          usr_q[i]   <= live_nxt[i];
          dirty_q[i] <= 1'b0;
        end else if (snap && !dirty_q[i]) begin
          usr_q[i]   <= live_nxt[i];
        end
      end
      if (wr_data && ptr == ADDR_W'(CTRL_ADDR)) ctrl_q <= wdata_i;
    end
  end

  always_comb begin
    rd_byte = ram_rd;
    if (ptr == ADDR_W'(CTRL_ADDR)) rd_byte = ctrl_q;
    for (int i = 0; i < TIME_REGS; i++)
      if (ptr == ADDR_W'(i)) rd_byte = usr_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_byte;
    end
  end

  a_r2_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvalid_o);

  a_r5_start_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !wr_i && !dirty_q[I_SEC]) |=> (usr_q[I_SEC] == live[I_SEC]));

  a_r6_stop_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_i) |=> (usr_q == live));

  a_r8_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !stop_i && !wrap && !wr_i) |=> $stable(usr_q));

  a_r9_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !wr_i && dirty_q[I_MIN]) |=> (live[I_MIN] == $past(usr_q[I_MIN])));

endmodule

// File: tb/tb_rtc_snap_regs.sv
module tb_rtc_snap_regs;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, osc_tick_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       rvalid_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  rtc_snap_regs #(.ADDR_W(6), .PRESC_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni, .start_i, .stop_i, .wr_i, .wdata_i, .rd_i, .osc_tick_i,
    .rdata_o, .rvalid_o
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each returned byte against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 unexpected read act=%h exp=none", rdata_o);
      end else begin
        chk(rdata_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic op(input logic s, input logic p, input logic w, input logic r,
                    input logic t, input logic [7:0] d);
    @(negedge clk);
    start_i = s; stop_i = p; wr_i = w; rd_i = r; osc_tick_i = t; wdata_i = d;
    @(negedge clk);
    start_i = 0; stop_i = 0; wr_i = 0; rd_i = 0; osc_tick_i = 0; wdata_i = '0;
  endtask

  task automatic sta();                 op(1, 0, 0, 0, 0, 8'h00); endtask
  task automatic sto();                 op(0, 1, 0, 0, 0, 8'h00); endtask
  task automatic wrb(input logic [7:0] d); op(0, 0, 1, 0, 0, d);  endtask
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, 1, 8'h00);
  endtask
  task automatic rdx(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    op(0, 0, 0, 1, 0, 8'h00);
  endtask

  task automatic set_time(input logic [7:0] b [7]);
    sta(); wrb(8'h00);
    for (int i = 0; i < 7; i++) wrb(b[i]);
    sto();
  endtask

  task automatic expect_time(input logic [7:0] b [7], input string tag);
    sta(); wrb(8'h00); sta();
    for (int i = 0; i < 7; i++) rdx(b[i], tag);
    sto();
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata_o, 8'h00, "R1 reset rdata");
    chk({7'd0, rvalid_o}, 8'h00, "R1 reset rvalid");
    rst_ni = 1'b1;

    // R1 reset contents, R13 control byte
    sta(); wrb(8'h00); sta();
    rdx(8'h00, "R1 sec"); rdx(8'h00, "R1 min"); rdx(8'h00, "R1 hour"); rdx(8'h01, "R1 dow");
    rdx(8'h01, "R1 date"); rdx(8'h01, "R1 month"); rdx(8'h00, "R1 year"); rdx(8'h00, "R13 ctrl reset");
    sto();

    // R4 RAM, R2 pointer load and increment
    sta(); wrb(8'h08); wrb(8'hAA); wrb(8'h55); wrb(8'h3C); sto();
    sta(); wrb(8'h3E); wrb(8'hC3); wrb(8'h5A); sto();
    sta(); wrb(8'h08); sta();
    rdx(8'hAA, "R4 ram 08"); rdx(8'h55, "R2 ram 09"); rdx(8'h3C, "R4 ram 0A");
    sto();

    // R3/R7: read runs through 3F into 00 after the counter moved
    sta(); wrb(8'h3E); sta();
    tk(DIV);
    rdx(8'hC3, "R3 ram 3E"); rdx(8'h5A, "R3 ram 3F"); rdx(8'h01, "R7 wrap snapshot");
    sto();

    // R8 copy frozen while live runs
    sta(); wrb(8'h00); sta();
    tk(DIV);
    rdx(8'h01, "R8 frozen copy");
    sto();

    // R6 STOP refresh, read without a new START
    sta(); wrb(8'h00); sta();
    tk(DIV);
    sto();
    rdx(8'h03, "R6 stop snapshot");

    // R5 START refresh
    sta(); wrb(8'h00);
    tk(DIV);
    sta();
    rdx(8'h04, "R5 start snapshot");
    sto();

    // R9 pending write kept across START, commit clears prescaler
    sta(); wrb(8'h00); wrb(8'h10);
    tk(2);
    sta(); wrb(8'h00); sta();
    rdx(8'h10, "R9 pending kept");
    sto();
    tk(DIV - 1);
    sta(); wrb(8'h00); sta();
    rdx(8'h10, "R9 prescaler cleared");
    sto();
    tk(1);
    sta(); wrb(8'h00); sta();
    rdx(8'h11, "R10 second step");
    sto();

    // R10 calendar carries
    set_time('{8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23});
    tk(DIV);
    expect_time('{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h03, 8'h23}, "R10 feb non-leap");
    set_time('{8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24});
    tk(DIV);
    expect_time('{8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24}, "R10 feb leap");
    set_time('{8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25});
    tk(DIV);
    expect_time('{8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h05, 8'h25}, "R10 30-day month");
    set_time('{8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99});
    tk(DIV);
    expect_time('{8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h01, 8'h00}, "R10 year wrap");
    set_time('{8'h59, 8'h12, 8'h05, 8'h02, 8'h10, 8'h06, 8'h30});
    tk(DIV);
    expect_time('{8'h00, 8'h13, 8'h05, 8'h02, 8'h10, 8'h06, 8'h30}, "R10 minute carry");

    // R11 halt bit
    sta(); wrb(8'h00); wrb(8'h85); sto();
    tk(2 * DIV);
    sta(); wrb(8'h00); sta();
    rdx(8'h85, "R11 halted");
    sto();
    sta(); wrb(8'h00); wrb(8'h05); sto();
    tk(DIV);
    sta(); wrb(8'h00); sta();
    rdx(8'h06, "R11 resumed");
    sto();

    // R12 START in the same cycle as a seconds advance
    tk(DIV - 1);
    op(1, 0, 0, 0, 1, 8'h00);
    wrb(8'h00);
    rdx(8'h07, "R12 post-tick capture");
    sto();

    // R13 control byte direct
    sta(); wrb(8'h07); wrb(8'h93);
    sta(); wrb(8'h07);
    rdx(8'h93, "R13 ctrl direct");
    sto();

    repeat (5) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing reads act=%0d exp=0", exp_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule